// File: doc/BRIEF.md
# Dual-Context Configurable Logic Tile

This block is one fine-grained cell of a reconfigurable fabric. Eight neighbour lines come in: four one-hop lines (north, south, east, west) and four four-hop lines. Three input selectors each pick one of the eight lines. The first pick steers a 2:1 function multiplexer that chooses between two operand paths, called operand A and operand B. Each operand path can invert its line or replace it with a constant. With these choices the cell forms AND, OR, XOR, pass-through and similar two-input functions. The result goes to the cell output either directly or through a flip-flop that has a synchronous clear. Four direction outputs are each fed by a 4:1 selector. The selector for a direction never offers the line that arrives from that same direction, so a signal cannot bounce back to where it came from.

The cell stores two complete 24-bit configuration words, one per context. A registered context-select input chooses which word drives every selector in the cell. Changing the select therefore swaps the whole cell function in a single cycle. Either word can be rewritten at any time through a parallel write port: a write enable, a bank bit and a 24-bit data word.

Top module: `dual_ctx_tile`

## Requirements
- R1: After a synchronous active-low reset, both stored words, the context register and the flip-flop are 0. With all-zero configuration, `f_out` equals north (`nb_in[0]`), `n_out` equals south, and `s_out`, `e_out` and `w_out` each equal north.
- R2: Neighbour line indices on `nb_in` are: 0 north, 1 south, 2 east, 3 west, 4 north-4, 5 south-4, 6 east-4, 7 west-4. The steering input takes the line indexed by config bits [2:0], operand A takes the line indexed by bits [5:3] and operand B takes the line indexed by bits [8:6].
- R3: The function result is operand A when the steering line is 1, and operand B when the steering line is 0.
- R4: Config bit 9 inverts the line used for operand A, and config bit 10 inverts the line used for operand B.
- R5: Config bit 11 (operand A) and config bit 12 (operand B) each replace that operand with the value of config bit 13. Inversion is not applied to this constant.
- R6: When config bit 14 is 0, `f_out` is the function result with no delay. When bit 14 is 1, `f_out` is a flip-flop that captures the function result on every clock edge.
- R7: While `ff_clr` is high, the next clock edge loads the flip-flop with 0. Neither stored word changes because of it.
- R8: The output selectors use code 0..3 in config bits [16:15] for `n_out`, [18:17] for `s_out`, [20:19] for `e_out` and [22:21] for `w_out`. Codes 0 to 2 pick the remaining one-hop directions in the order north, south, east, west with the output's own direction left out. Code 3 picks `f_out`.
- R9: A change of `ctx_sel` takes effect on the following clock edge. Before that edge the old context still drives the cell.
- R10: When `cfg_we` is high, `cfg_data` is written into the word chosen by `cfg_bank` at the clock edge. A write to the active word is visible right after that edge. A write to the inactive word leaves the outputs unchanged.
- R11: Config bit 23 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctx_sel | input | 1 | Context select, registered |
| cfg_we | input | 1 | Configuration write enable |
| cfg_bank | input | 1 | Stored word to write |
| cfg_data | input | 24 | Configuration word to write |
| ff_clr | input | 1 | Synchronous clear of the output flip-flop |
| nb_in | input | 8 | Neighbour lines N, S, E, W, N4, S4, E4, W4 (bit 0 first) |
| f_out | output | 1 | Cell function output |
| n_out | output | 1 | North output |
| s_out | output | 1 | South output |
| e_out | output | 1 | East output |
| w_out | output | 1 | West output |

## Verification
The hardest case to reach is an edge in which the select flips while the operand lines also change. To check it, the output must be sampled twice around the same edge: just before it, when the old context still governs the new inputs, and just after it, when the new context governs them. The stimulus loads an AND word and an OR word into the two contexts. It then toggles the select on every cycle while stepping through all operand pairs, so each pair is seen under both contexts. It compares hard-coded truth values on both sides of the edge. A long random phase follows. It mixes writes to the active and inactive words, clears and select flips, and a behavioural model tracks the outputs every cycle.

// File: rtl/tile_pkg.sv
package tile_pkg;
    localparam int CFG_W  = 24;
    localparam int CORE_W = CFG_W - 1;
    localparam int NB_N   = 8;
    localparam int SRC_W  = $clog2(NB_N);
    localparam int DIR_N  = 4;
    localparam int RT_W   = $clog2(DIR_N);

    typedef struct packed {
        logic [RT_W-1:0]  w_rt;
        logic [RT_W-1:0]  e_rt;
        logic [RT_W-1:0]  s_rt;
        logic [RT_W-1:0]  n_rt;
        logic             reg_out;
        logic             cval;
        logic             opb_const;
        logic             opa_const;
        logic             opb_inv;
        logic             opa_inv;
        logic [SRC_W-1:0] opb_src;
        logic [SRC_W-1:0] opa_src;
        logic [SRC_W-1:0] steer_src;
    } tile_cfg_t;
endpackage

// File: rtl/tile_cfg_store.sv
module tile_cfg_store
    import tile_pkg::*;
#(
    parameter int N_CTX = 2,
    localparam int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTX_W-1:0] ctx_sel,
    input  logic             cfg_we,
    input  logic [CTX_W-1:0] cfg_bank,
    input  logic [CFG_W-1:0] cfg_data,
    output tile_cfg_t        act_cfg
);
    typedef struct packed {
        logic [N_CTX-1:0][CFG_W-1:0] bank;
        logic [CTX_W-1:0]            sel;
    } store_st_t;

    store_st_t st_d, st_q;
    logic [CFG_W-1:0] act_word;

    always_comb begin
        st_d     = st_q;
        st_d.sel = ctx_sel;
        if (cfg_we && (int'(cfg_bank) < N_CTX)) begin
            st_d.bank[cfg_bank] = cfg_data;
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign act_word = (int'(st_q.sel) < N_CTX) ? st_q.bank[st_q.sel] : '0;
    assign act_cfg  = tile_cfg_t'(act_word[CORE_W-1:0]);

    a_r9_ctx_next: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.sel == $past(ctx_sel)));

    a_r10_active_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_bank == ctx_sel) |=> (act_word == $past(cfg_data)));

    a_r7_hold_words: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(st_q.bank));
endmodule

// File: rtl/tile_logic.sv
module tile_logic
    import tile_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NB_N-1:0]      nb_in,
    input  logic [2:0][SRC_W-1:0] x_src,
    input  logic [1:0]           op_inv,
    input  logic [1:0]           op_const,
    input  logic                 cval,
    input  logic                 reg_out,
    input  logic                 ff_clr,
    output logic                 f_out
);
    typedef struct packed {
        logic ff;
    } logic_st_t;

    logic_st_t st_d, st_q;
    logic [1:0] op;
    logic       steer;
    logic       func;

    assign steer = nb_in[x_src[0]];

    for (genvar j = 0; j < 2; j++) begin : g_op
        assign op[j] = op_const[j] ? cval : (nb_in[x_src[j+1]] ^ op_inv[j]);
    end

    assign func = steer ? op[0] : op[1];

    always_comb begin
        st_d    = st_q;
        st_d.ff = ff_clr ? 1'b0 : func;
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign f_out = reg_out ? st_q.ff : func;

    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !ff_clr |=> (st_q.ff == $past(func)));

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ff_clr |=> (st_q.ff == 1'b0));

    a_r5_const_a: assert property (@(posedge clk) disable iff (!rst_n)
        (op_const[0] && steer) |-> (func == cval));
endmodule

// File: rtl/tile_route.sv
module tile_route
    import tile_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DIR_N-1:0]           dir_in,
    input  logic                       f_in,
    input  logic [DIR_N-1:0][RT_W-1:0] rt_sel,
    output logic [DIR_N-1:0]           dir_out
);
    for (genvar d = 0; d < DIR_N; d++) begin : g_dir
        logic [DIR_N-1:0] cand;
        for (genvar k = 0; k < DIR_N - 1; k++) begin : g_cand
            localparam int SRC = (k < d) ? k : k + 1;
            assign cand[k] = dir_in[SRC];
        end
        assign cand[DIR_N-1] = f_in;
        assign dir_out[d]    = cand[rt_sel[d]];

        a_r8_route_f: assert property (@(posedge clk) disable iff (!rst_n)
            (rt_sel[d] == RT_W'(DIR_N - 1)) |-> (dir_out[d] == f_in));
    end
endmodule

// File: rtl/dual_ctx_tile.sv
module dual_ctx_tile
    import tile_pkg::*;
#(
    parameter int N_CTX = 2,
    localparam int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTX_W-1:0] ctx_sel,
    input  logic             cfg_we,
    input  logic [CTX_W-1:0] cfg_bank,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             ff_clr,
    input  logic [NB_N-1:0]  nb_in,
    output logic             f_out,
    output logic             n_out,
    output logic             s_out,
    output logic             e_out,
    output logic             w_out
);
    tile_cfg_t                  cfg;
    logic                       f_int;
    logic [DIR_N-1:0]           dir_out;
    logic [DIR_N-1:0][RT_W-1:0] rt_sel;
    logic [2:0][SRC_W-1:0]      x_src;

    tile_cfg_store #(.N_CTX(N_CTX)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctx_sel  (ctx_sel),
        .cfg_we   (cfg_we),
        .cfg_bank (cfg_bank),
        .cfg_data (cfg_data),
        .act_cfg  (cfg)
    );

    assign x_src = {cfg.opb_src, cfg.opa_src, cfg.steer_src};

    tile_logic u_logic (
        .clk      (clk),
        .rst_n    (rst_n),
        .nb_in    (nb_in),
        .x_src    (x_src),
        .op_inv   ({cfg.opb_inv, cfg.opa_inv}),
        .op_const ({cfg.opb_const, cfg.opa_const}),
        .cval     (cfg.cval),
        .reg_out  (cfg.reg_out),
        .ff_clr   (ff_clr),
        .f_out    (f_int)
    );

    assign rt_sel = {cfg.w_rt, cfg.e_rt, cfg.s_rt, cfg.n_rt};

    tile_route u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_in  (nb_in[DIR_N-1:0]),
        .f_in    (f_int),
        .rt_sel  (rt_sel),
        .dir_out (dir_out)
    );

    assign f_out = f_int;
    assign n_out = dir_out[0];
    assign s_out = dir_out[1];
    assign e_out = dir_out[2];
    assign w_out = dir_out[3];
endmodule

// File: tb/dual_ctx_tile_bench.sv
module dual_ctx_tile_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctx_sel, cfg_we, cfg_bank, ff_clr;
    logic [23:0] cfg_data;
    logic [7:0]  nb_in;
    logic        f_out, n_out, s_out, e_out, w_out;

    int checks = 0;
    int errors = 0;

    logic [23:0] mb [0:1];
    logic        msel;
    logic        mff;

    always #4 clk = ~clk;

    dual_ctx_tile u_dual_ctx_tile (
        .clk(clk), .rst_n(rst_n), .ctx_sel(ctx_sel), .cfg_we(cfg_we),
        .cfg_bank(cfg_bank), .cfg_data(cfg_data), .ff_clr(ff_clr),
        .nb_in(nb_in), .f_out(f_out), .n_out(n_out), .s_out(s_out),
        .e_out(e_out), .w_out(w_out)
    );

    function automatic logic m_func(input logic [23:0] c, input logic [7:0] nb);
        logic st, ya, yb;
        st = nb[c[2:0]];
        ya = c[11] ? c[13] : (nb[c[5:3]] ^ c[9]);
        yb = c[12] ? c[13] : (nb[c[8:6]] ^ c[10]);
        return st ? ya : yb;
    endfunction

    function automatic logic m_dir(input int d, input logic [23:0] c,
                                   input logic [7:0] nb, input logic f);
        int s;
        int lst [3];
        s = int'(c[15 + 2*d +: 2]);
        case (d)
            0: lst = '{1, 2, 3};
            1: lst = '{0, 2, 3};
            2: lst = '{0, 1, 3};
            default: lst = '{0, 1, 2};
        endcase
        if (s == 3) return f;
        return nb[lst[s]];
    endfunction

    always @(posedge clk) begin
        logic fn;
        if (!rst_n) begin
            mb[0] = '0; mb[1] = '0; msel = 1'b0; mff = 1'b0;
        end else begin
            fn  = m_func(mb[msel], nb_in);
            mff = ff_clr ? 1'b0 : fn;
            if (cfg_we) mb[cfg_bank] = cfg_data;
            msel = ctx_sel;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all(input string tag);
        logic [23:0] c;
        logic        ef;
        logic [3:0]  act;
        c   = mb[msel];
        ef  = c[14] ? mff : m_func(c, nb_in);
        chk(f_out, ef, tag);
        act = {w_out, e_out, s_out, n_out};
        for (int d = 0; d < 4; d++) chk(act[d], m_dir(d, c, nb_in, ef), "R8 route");
    endtask

    task automatic tick(input string tag);
        #3;
        cmp_all(tag);
        @(negedge clk);
    endtask

    function automatic logic [4:0] outs();
        return {f_out, n_out, s_out, e_out, w_out};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [4:0] rec;
        rst_n = 1'b0; ctx_sel = 1'b0; cfg_we = 1'b0; cfg_bank = 1'b0;
        cfg_data = '0; ff_clr = 1'b0; nb_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all-zero configuration after reset
        nb_in = 8'b0000_0101;
        #3;
        chk(f_out, 1'b1, "R1 f_out=N");
        chk(n_out, 1'b0, "R1 n_out=S");
        chk(s_out, 1'b1, "R1 s_out=N");
        chk(e_out, 1'b1, "R1 e_out=N");
        chk(w_out, 1'b1, "R1 w_out=N");
        @(negedge clk);

        // R9 R3 R5: AND in context 0, OR in context 1, select toggled every cycle
        cfg_we = 1'b1; cfg_bank = 1'b0; cfg_data = 24'h00101A; tick("R10 write");
        cfg_bank = 1'b1; cfg_data = 24'h0028C2; tick("R10 write");
        cfg_we = 1'b0; tick("R5");
        for (int i = 0; i < 8; i++) begin
            logic a, b, o, nw;
            a = i[1]; b = i[2]; o = ctx_sel; nw = ~o;
            nb_in   = {4'b0, b, a, 2'b0};
            ctx_sel = nw;
            #3;
            chk(f_out, o ? (a | b) : (a & b), "R9 old context before edge");
            cmp_all("R3");
            @(posedge clk);
            #2;
            chk(f_out, nw ? (a | b) : (a & b), "R9 new context after edge");
            @(negedge clk);
        end

        // R6 R7: registered constant 1, clear, then recapture
        ctx_sel = 1'b0;
        cfg_we = 1'b1; cfg_bank = 1'b0; cfg_data = 24'h007800; tick("R6");
        cfg_we = 1'b0; tick("R6");
        #3; chk(f_out, 1'b1, "R6 registered capture"); @(negedge clk);
        ff_clr = 1'b1; tick("R7");
        ff_clr = 1'b0;
        #3; chk(f_out, 1'b0, "R7 cleared"); @(negedge clk);
        #3; chk(f_out, 1'b1, "R7 word intact after clear"); @(negedge clk);

        // R10 inactive write, R11 reserved bit
        nb_in = 8'hC6;
        cfg_we = 1'b1; cfg_bank = 1'b0; cfg_data = 24'h2A0D13; tick("R10");
        cfg_bank = 1'b1; cfg_data = 24'hAA0D13;
        #3; rec = outs(); cmp_all("R10"); @(negedge clk);
        cfg_we = 1'b0;
        #3;
        for (int k = 0; k < 5; k++) chk(outs()[k], rec[k], "R10 inactive write no effect");
        @(negedge clk);
        ctx_sel = 1'b1; tick("R11");
        #3;
        for (int k = 0; k < 5; k++) chk(outs()[k], rec[k], "R11 reserved bit ignored");
        @(negedge clk);

        // Random mix: R2 R4 R5 R6 R7 R8 R9 R10
        for (int n = 0; n < 3000; n++) begin
            nb_in    = 8'($urandom);
            if ($urandom % 4 == 0) ctx_sel = ~ctx_sel;
            cfg_we   = ($urandom % 5 == 0);
            cfg_bank = 1'($urandom);
            cfg_data = 24'($urandom);
            ff_clr   = ($urandom % 8 == 0);
            tick("R2 R4 R5 R6 R7 R9 R10 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule